// File: doc/BRIEF.md
# Configurable-Factor Parallel-to-Serial Transmitter

This block turns a parallel word into a serial bit stream for a differential output driver. A load register and a shift register both run on a fast clock at the serial bit rate. A modulo-N counter paces them: once every N fast cycles it raises a strobe. At the end of that strobe cycle the shift register takes the held word, so one word follows the next with no idle bit between them. The most significant bit of each word goes out first.

The factor N is a static parameter. The serializer handles the factors 4, 6, 7, 8 and 10. Factors 1 and 2 skip the serializer and use a bypass built from two output registers. Factor 1 gives a single-data-rate bit. Factor 2 gives a double-data-rate pair per fast cycle, and the upper bit of the pair belongs to the first half-period. The core logic must run on a clock related to the fast clock. It uses the strobe output to know when a word has been consumed.

Top module: `wser_tx`

## Requirements
- R1: The FACTOR parameter accepts only 1, 2, 4, 6, 7, 8 and 10. Any other value stops elaboration. Factors 4 and above use the serializer; 1 and 2 use the bypass.
- R2: After a load edge, `tx_bit` presents bit N-1 of the loaded word. On each of the next N-1 fast cycles it presents the next lower bit, ending with bit 0.
- R3: In serializer mode `word_taken` is high for exactly one fast cycle out of every N. That cycle is the one just before the load edge.
- R4: At the load edge the shift register takes the word held in the load register. The load register holds the value of `par_in` seen at the previous fast edge. Bit 0 of one word is followed directly by bit N-1 of the next word.
- R5: When N is below the input width, bits N and above of `par_in` have no effect on `tx_bit`.
- R6: While `rst_n` is low, `tx_bit`, `tx_pair` and `word_taken` are low in serializer mode. After release, `word_taken` first rises after N-1 fast edges, and the first word appears after the Nth edge.
- R7: With FACTOR 1, both bits of `tx_pair` and `tx_bit` equal `par_in[0]` as sampled at the previous fast edge. `word_taken` stays high outside reset.
- R8: With FACTOR 2, `tx_pair` equals `{par_in[1], par_in[0]}` as sampled at the previous fast edge. Bit 1 is the first half-period and is also driven on `tx_bit`.
- R9: In serializer mode, both bits of `tx_pair` equal `tx_bit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast clock at the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_in | input | WORD_W | Parallel word from the core |
| tx_bit | output | 1 | Serial bit, or the first-half bit in bypass |
| tx_pair | output | 2 | Output pair: {first half, second half} |
| word_taken | output | 1 | Load strobe, high in the cycle before a word is loaded |

## Verification
The hardest case to reach is the word boundary: the cycle where bit 0 of one word gives way to bit N-1 of the next. It only works if the new word was set up in the load register one edge earlier. The stimulus changes `par_in` right after each load edge and walks a table of words with alternating and solid patterns, so every boundary is checked for a gap or a stale bit. The table sets the upper bits of each word, which tests the unused-bit rule. A second reset is applied in the middle of a frame to check that the counter restarts.

// File: rtl/wser_pkg.sv
package wser_pkg;

   typedef enum logic [1:0] {
      PATH_SER = 2'd0,
      PATH_SDR = 2'd1,
      PATH_DDR = 2'd2
   } path_e;

   function automatic bit factor_ok(input int f);
      return (f == 1) || (f == 2) || (f == 4) || (f == 6) ||
             (f == 7) || (f == 8) || (f == 10);
   endfunction

   function automatic path_e path_of(input int f);
      if (f == 1) return PATH_SDR;
      if (f == 2) return PATH_DDR;
      return PATH_SER;
   endfunction

   function automatic int cnt_width(input int f);
      return (f <= 2) ? 1 : $clog2(f);
   endfunction

endpackage

// File: rtl/wser_loadgen.sv
module wser_loadgen #(
   parameter int N = 7
) (
   input  logic clk_fast,
   input  logic rst_n,
   output logic load_en
);
   localparam int CW = wser_pkg::cnt_width(N);
   localparam logic [CW-1:0] LAST = CW'(N - 1);

   if (N < 4) begin : g_bad_n
      $error("wser_loadgen needs N of at least 4");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign load_en = (cnt_q == LAST);

   // R3
   strobe_gap_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      load_en |=> !load_en);

   // R3
   cnt_bound_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/wser_shifter.sv
module wser_shifter #(
   parameter int N = 7,
   parameter int W = 10
) (
   input  logic         clk_fast,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] din,
   output logic         ser_bit
);
   if (W < N) begin : g_bad_w
      $error("wser_shifter input narrower than factor");
   end

   logic [N-1:0] hold_q;
   logic [N-1:0] shift_q;

   if (W > N) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^din[W-1:N];
   end

   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n) hold_q <= '0;
      else        hold_q <= din[N-1:0];
   end

   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n)       shift_q <= '0;
      else if (load_en) shift_q <= hold_q;
      else              shift_q <= {shift_q[N-2:0], 1'b0};
   end

   assign ser_bit = shift_q[N-1];

   // R4
   reload_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      load_en |=> (shift_q == $past(hold_q)));

   // R2
   msb_next_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      !load_en |=> (ser_bit == $past(shift_q[N-2])));

endmodule

// File: rtl/wser_bypass.sv
module wser_bypass #(
   parameter int  W   = 10,
   parameter bit  DDR = 1'b1
) (
   input  logic         clk_fast,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [1:0]   pair
);
   logic hi_q, lo_q;

   if (W > 2) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^din[W-1:2];
   end

   if (DDR) begin : g_ddr
      always_ff @(posedge clk_fast or negedge rst_n) begin
         if (!rst_n) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
         end else begin
            hi_q <= din[1];
            lo_q <= din[0];
         end
      end

      // R8
      ddr_pair_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
         1'b1 |=> (pair == {$past(din[1]), $past(din[0])}));
   end else begin : g_sdr
      logic unused_b1;
      assign unused_b1 = din[1];

      always_ff @(posedge clk_fast or negedge rst_n) begin
         if (!rst_n) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
         end else begin
            hi_q <= din[0];
            lo_q <= din[0];
         end
      end

      // R7
      sdr_pair_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
         1'b1 |=> (pair[1] == pair[0] && pair[1] == $past(din[0])));
   end

   assign pair = {hi_q, lo_q};

endmodule

// File: rtl/wser_tx.sv
module wser_tx #(
   parameter int FACTOR = 7,
   parameter int WORD_W = 10
) (
   input  logic              clk_fast,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] par_in,
   output logic              tx_bit,
   output logic [1:0]        tx_pair,
   output logic              word_taken
);
   import wser_pkg::*;

   localparam path_e PATH = path_of(FACTOR);

   // R1
   if (!factor_ok(FACTOR)) begin : g_bad_factor
      $error("wser_tx FACTOR must be 1, 2, 4, 6, 7, 8 or 10");
   end
   if (WORD_W < 2 || WORD_W > 10 || WORD_W < FACTOR) begin : g_bad_width
      $error("wser_tx WORD_W must cover FACTOR and lie in 2..10");
   end

   if (PATH == PATH_SER) begin : g_ser
      logic load_en;
      logic ser_bit;

      wser_loadgen #(.N(FACTOR)) u_loadgen (
         .clk_fast (clk_fast),
         .rst_n    (rst_n),
         .load_en  (load_en)
      );

      wser_shifter #(.N(FACTOR), .W(WORD_W)) u_shifter (
         .clk_fast (clk_fast),
         .rst_n    (rst_n),
         .load_en  (load_en),
         .din      (par_in),
         .ser_bit  (ser_bit)
      );

      assign tx_bit     = ser_bit;
      assign tx_pair    = {ser_bit, ser_bit};
      assign word_taken = load_en;
   end else begin : g_bypass
      logic [1:0] pair;

      wser_bypass #(.W(WORD_W), .DDR(PATH == PATH_DDR)) u_bypass (
         .clk_fast (clk_fast),
         .rst_n    (rst_n),
         .din      (par_in),
         .pair     (pair)
      );

      assign tx_bit     = pair[1];
      assign tx_pair    = pair;
      assign word_taken = rst_n;
   end

endmodule

// File: tb/wser_tx_test.sv
`timescale 1ns/1ps
module wser_tx_test;
   localparam int WW = 10;
   localparam int NV = 8;
   localparam logic [WW-1:0] VEC [NV] = '{
      10'h3A5, 10'h1FF, 10'h000, 10'h2C3,
      10'h3FF, 10'h155, 10'h2AA, 10'h0F0
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [WW-1:0] par_in = '0;

   logic       tx7, tx4, tx10, txs, txd;
   logic [1:0] pr7, pr4, pr10, prs, prd;
   logic       tk7, tk4, tk10, tks, tkd;

   int vectors = 0;
   int fails   = 0;

   always #2.5 clk = ~clk;

   wser_tx #(.FACTOR(7),  .WORD_W(WW)) uut   (.clk_fast(clk), .rst_n(rst_n), .par_in(par_in),
      .tx_bit(tx7),  .tx_pair(pr7),  .word_taken(tk7));
   wser_tx #(.FACTOR(4),  .WORD_W(WW)) u_f4  (.clk_fast(clk), .rst_n(rst_n), .par_in(par_in),
      .tx_bit(tx4),  .tx_pair(pr4),  .word_taken(tk4));
   wser_tx #(.FACTOR(10), .WORD_W(WW)) u_f10 (.clk_fast(clk), .rst_n(rst_n), .par_in(par_in),
      .tx_bit(tx10), .tx_pair(pr10), .word_taken(tk10));
   wser_tx #(.FACTOR(1),  .WORD_W(WW)) u_sdr (.clk_fast(clk), .rst_n(rst_n), .par_in(par_in),
      .tx_bit(txs),  .tx_pair(prs),  .word_taken(tks));
   wser_tx #(.FACTOR(2),  .WORD_W(WW)) u_ddr (.clk_fast(clk), .rst_n(rst_n), .par_in(par_in),
      .tx_bit(txd),  .tx_pair(prd),  .word_taken(tkd));

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
      end
   endtask

   task automatic grab(input int f, output logic tx, output logic [1:0] pr, output logic tk);
      case (f)
         4:       begin tx = tx4;  pr = pr4;  tk = tk4;  end
         10:      begin tx = tx10; pr = pr10; tk = tk10; end
         default: begin tx = tx7;  pr = pr7;  tk = tk7;  end
      endcase
   endtask

   task automatic run_ser(input int f);
      logic tx, tk;
      logic [1:0] pr;
      @(negedge clk);
      rst_n  = 1'b0;
      par_in = VEC[0];
      #1;
      grab(f, tx, pr, tk);
      check("R6 async clear tx", {1'b0, tx}, 2'b00);
      check("R6 async clear strobe", {1'b0, tk}, 2'b00);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int e = 1; e < f; e++) begin
         @(posedge clk);
         @(negedge clk);
         grab(f, tx, pr, tk);
         check("R6 idle before first load", {1'b0, tx}, 2'b00);
         check("R6 R3 first strobe timing", {1'b0, tk}, {1'b0, e == f - 1});
      end
      for (int k = 0; k < NV; k++) begin
         for (int j = 0; j < f; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (j == 0) par_in = VEC[(k + 1) % NV];
            grab(f, tx, pr, tk);
            check((f < WW) ? "R5 R2 R4 R1 serial bit" : "R2 R4 R1 serial bit",
                  {1'b0, tx}, {1'b0, VEC[k][f - 1 - j]});
            check("R9 pair mirrors bit", pr, {tx, tx});
            check("R3 strobe", {1'b0, tk}, {1'b0, j == f - 1});
         end
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R6 reset tx", {1'b0, tx7}, 2'b00);
      check("R6 reset pair", pr7, 2'b00);
      check("R6 reset strobe", {1'b0, tk7}, 2'b00);

      run_ser(7);
      repeat (3) @(posedge clk);
      run_ser(7);
      run_ser(4);
      run_ser(10);

      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         par_in = VEC[i];
         @(posedge clk);
         @(negedge clk);
         check("R7 sdr pair", prs, {VEC[i][0], VEC[i][0]});
         check("R7 sdr bit", {1'b0, txs}, {1'b0, VEC[i][0]});
         check("R7 sdr strobe", {1'b0, tks}, 2'b01);
         check("R8 ddr pair", prd, VEC[i][1:0]);
         check("R8 ddr first half", {1'b0, txd}, {1'b0, VEC[i][1]});
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule